// File: doc/BRIEF.md
# Prioritised Interrupt CPU Interface

This block is the per-processor front end of an interrupt controller. An interrupt distributor supplies four things as flat vectors: an enable bit, a pending bit and an 8-bit priority for each interrupt line, plus a global enable. From these, the block keeps choosing the most urgent interrupt that is both enabled and pending. It compares that choice against a programmable priority mask and against the priority of the interrupt currently being serviced. It raises the processor interrupt line only when the candidate clears both. A lower priority value is more urgent.

The processor uses a small register window. It can enable the interface, set the priority mask, read the highest-pending ID, read the running priority, acknowledge an interrupt and signal end-of-interrupt. Acknowledging an interrupt does three things: it makes that interrupt the running one, it sends a one-cycle clear-pending pulse back to the distributor, and it links the interrupt to the one it preempted. Ending an interrupt that is not the running one removes it from that chain. A later completion then returns to the correct earlier interrupt. The value 1023 means "no interrupt" everywhere.

Top module: `irq_cpu_if`

## Requirements
- R1: After reset the interrupt line is low and the interface is disabled. Highest-pending (offset 0x18) reads 1023, the mask (offset 0x04) reads 0xF0 and running priority (offset 0x14) reads 0x100.
- R2: The candidate is the enabled and pending interrupt with the lowest priority value. On equal values the lowest ID wins. Highest-pending reads its ID when the candidate's priority is at or below the mask.
- R3: When the candidate's priority value is above the mask, or when no interrupt is enabled and pending, highest-pending reads 1023 and the interrupt line is low.
- R4: The interrupt line is high only when the candidate's priority is at or below the mask and strictly below the running priority. A candidate equal to the running priority does not preempt.
- R5: When the distributor enable is low, or control bit 0 (offset 0x00) is clear, the line is low and highest-pending reads 1023.
- R6: A read of acknowledge (offset 0x0C) when the line is low returns 1023. It changes neither the running priority nor the clear-pending output.
- R7: A read of acknowledge when the line is high returns the candidate ID. It pulses the clear-pending output for exactly one cycle with that ID, and sets the running priority to the candidate's priority. Each read strobe acts once.
- R8: Writing the running ID to end-of-interrupt (offset 0x10, ID in bits 9:0) restores the priority of the interrupt it preempted, or 0x100 if it preempted none.
- R9: Writing the ID of a preempted, non-running interrupt to end-of-interrupt leaves the running priority unchanged and unlinks that interrupt. The later completion of the interrupt that preempted it then restores the priority of the one below.
- R10: An end-of-interrupt with an ID at or above the implemented count, or with nothing running, changes nothing.
- R11: A change on the enable, pending or priority inputs is reflected on the interrupt line and in highest-pending after exactly one rising clock edge, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dist_en | input | 1 | Global distributor enable |
| irq_enable | input | NUM_IRQ | Per-interrupt enable bits |
| irq_pend | input | NUM_IRQ | Per-interrupt pending bits |
| irq_prio | input | 8*NUM_IRQ | Priority of interrupt i in bits 8i+7:8i |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 10 | Write data |
| bus_rdata | output | 32 | Read data, valid from the edge that samples the read strobe |
| irq_out | output | 1 | Interrupt request to the processor |
| pend_clr | output | 1 | One-cycle pulse: distributor clears the pending bit |
| pend_clr_id | output | 10 | ID to clear while pend_clr is high |

## Verification
The results arrive at two different times. The interrupt line and highest-pending follow one rising edge after an input vector changes, because the search result is registered. Read data, the clear-pending pulse and the new running priority all appear at the same edge that samples the bus strobe. The bench drives all inputs at falling edges and samples each result at the falling edge after the edge that produces it. For the latency requirement it also samples just after driving, before any edge, to confirm the old value still holds. After each acknowledge the bench clears the modelled pending bit and lets one further edge pass before it compares highest-pending again.

// File: rtl/irq_cif_pkg.sv
package irq_cif_pkg;
  localparam int            ID_W      = 10;
  localparam int            PRIO_W    = 8;
  localparam int            RPRIO_W   = PRIO_W + 1;
  localparam logic [ID_W-1:0]    ID_NONE   = 10'd1023;
  localparam logic [RPRIO_W-1:0] RPRIO_IDLE = 9'h100;
  localparam int            ADDR_W    = 8;
  localparam int            RDATA_W   = 32;
  localparam logic [ADDR_W-1:0] OFF_CTRL   = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_PMASK  = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_ACK    = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_EOI    = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_RUNP   = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_HIPEND = 8'h18;
endpackage

// File: rtl/irq_prio_search.sv
module irq_prio_search
  import irq_cif_pkg::*;
#(
  parameter int NUM_IRQ = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_IRQ-1:0]        cand_en,
  input  logic [NUM_IRQ-1:0]        cand_pend,
  input  logic [NUM_IRQ*PRIO_W-1:0] cand_prio,
  output logic [ID_W-1:0]           best_id_q,
  output logic [RPRIO_W-1:0]        best_prio_q
);
  logic [ID_W-1:0]    best_id_d;
  logic [RPRIO_W-1:0] best_prio_d;

  // ascending scan, strict compare: ties keep the lower ID
  always_comb begin
    best_id_d   = ID_NONE;
    best_prio_d = RPRIO_IDLE;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (cand_en[i] && cand_pend[i] &&
          ({1'b0, cand_prio[i*PRIO_W +: PRIO_W]} < best_prio_d)) begin
        best_prio_d = {1'b0, cand_prio[i*PRIO_W +: PRIO_W]};
        best_id_d   = ID_W'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_id_q   <= ID_NONE;
      best_prio_q <= RPRIO_IDLE;
    end else begin
      best_id_q   <= best_id_d;
      best_prio_q <= best_prio_d;
    end
  end
endmodule

// File: rtl/irq_nest_chain.sv
module irq_nest_chain
  import irq_cif_pkg::*;
#(
  parameter int NUM_IRQ = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ack_go,
  input  logic [ID_W-1:0]           ack_id,
  input  logic [PRIO_W-1:0]         ack_prio,
  input  logic                      eoi_go,
  input  logic [ID_W-1:0]           eoi_id,
  input  logic [NUM_IRQ*PRIO_W-1:0] cur_prio,
  output logic [ID_W-1:0]           run_id,
  output logic [RPRIO_W-1:0]        run_prio
);
  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  logic [ID_W-1:0]    prev_q [NUM_IRQ];
  logic [ID_W-1:0]    prev_d [NUM_IRQ];
  logic [ID_W-1:0]    next_q [NUM_IRQ];
  logic [ID_W-1:0]    next_d [NUM_IRQ];
  logic [NUM_IRQ-1:0] active_q, active_d;
  logic [ID_W-1:0]    run_id_q, run_id_d;
  logic [RPRIO_W-1:0] run_prio_q, run_prio_d;

  logic               eoi_ok;
  logic [IDX_W-1:0]   e_idx, r_idx, a_idx;
  logic [ID_W-1:0]    e_pred, e_succ;

  assign eoi_ok = eoi_go && (eoi_id < ID_W'(NUM_IRQ)) && (run_id_q != ID_NONE);
  assign e_idx  = eoi_id[IDX_W-1:0];
  assign r_idx  = run_id_q[IDX_W-1:0];
  assign a_idx  = ack_id[IDX_W-1:0];
  assign e_pred = prev_q[e_idx];
  assign e_succ = next_q[e_idx];

  always_comb begin
    prev_d     = prev_q;
    next_d     = next_q;
    active_d   = active_q;
    run_id_d   = run_id_q;
    run_prio_d = run_prio_q;
    if (ack_go) begin
      if (run_id_q != ID_NONE) next_d[r_idx] = ack_id;
      prev_d[a_idx]   = run_id_q;
      active_d[a_idx] = 1'b1;
      run_id_d        = ack_id;
      run_prio_d      = {1'b0, ack_prio};
    end else if (eoi_ok) begin
      if (eoi_id == run_id_q) begin
        active_d[e_idx] = 1'b0;
        run_id_d        = e_pred;
        run_prio_d      = (e_pred == ID_NONE) ? RPRIO_IDLE :
                          {1'b0, cur_prio[e_pred[IDX_W-1:0]*PRIO_W +: PRIO_W]};
      end else if (active_q[e_idx]) begin
        // unlink in place: successor inherits this node's predecessor
        active_d[e_idx]             = 1'b0;
        prev_d[e_succ[IDX_W-1:0]]   = e_pred;
        if (e_pred != ID_NONE) next_d[e_pred[IDX_W-1:0]] = e_succ;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_IRQ; i++) begin
        prev_q[i] <= ID_NONE;
        next_q[i] <= ID_NONE;
      end
      active_q   <= '0;
      run_id_q   <= ID_NONE;
      run_prio_q <= RPRIO_IDLE;
    end else if (ack_go || eoi_ok) begin
      prev_q     <= prev_d;
      next_q     <= next_d;
      active_q   <= active_d;
      run_id_q   <= run_id_d;
      run_prio_q <= run_prio_d;
    end
  end

  assign run_id   = run_id_q;
  assign run_prio = run_prio_q;
endmodule

// File: rtl/irq_cif_regs.sv
module irq_cif_regs
  import irq_cif_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dist_en,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [ID_W-1:0]    bus_wdata,
  input  logic [ID_W-1:0]    best_id,
  input  logic [RPRIO_W-1:0] best_prio,
  input  logic [RPRIO_W-1:0] run_prio,
  output logic               cpu_en,
  output logic [PRIO_W-1:0]  pmask,
  output logic [RDATA_W-1:0] bus_rdata,
  output logic               irq_fire,
  output logic               ack_go,
  output logic [ID_W-1:0]    ack_id,
  output logic [PRIO_W-1:0]  ack_prio,
  output logic               eoi_go,
  output logic [ID_W-1:0]    eoi_id,
  output logic               pend_clr,
  output logic [ID_W-1:0]    pend_clr_id
);
  logic               cpu_en_q, cpu_en_d;
  logic [PRIO_W-1:0]  pmask_q, pmask_d;
  logic [RDATA_W-1:0] rdata_q, rdata_d;
  logic               clr_q;
  logic [ID_W-1:0]    clr_id_q, clr_id_d;
  logic               rd_stb, wr_stb, visible;
  logic [ID_W-1:0]    hp_id;

  assign rd_stb  = bus_sel && !bus_wr;
  assign wr_stb  = bus_sel && bus_wr;
  assign visible = dist_en && cpu_en_q && (best_id != ID_NONE) &&
                   (best_prio <= {1'b0, pmask_q});
  assign hp_id    = visible ? best_id : ID_NONE;
  assign irq_fire = visible && (best_prio < run_prio);

  assign ack_go   = rd_stb && (bus_addr == OFF_ACK) && irq_fire;
  assign ack_id   = best_id;
  assign ack_prio = best_prio[PRIO_W-1:0];
  assign eoi_go   = wr_stb && (bus_addr == OFF_EOI);
  assign eoi_id   = bus_wdata;

  always_comb begin
    cpu_en_d = cpu_en_q;
    pmask_d  = pmask_q;
    if (wr_stb && bus_addr == OFF_CTRL)  cpu_en_d = bus_wdata[0];
    if (wr_stb && bus_addr == OFF_PMASK) pmask_d  = bus_wdata[PRIO_W-1:0];
  end

  always_comb begin
    case (bus_addr)
      OFF_CTRL:   rdata_d = RDATA_W'(cpu_en_q);
      OFF_PMASK:  rdata_d = RDATA_W'(pmask_q);
      OFF_ACK:    rdata_d = RDATA_W'(irq_fire ? best_id : ID_NONE);
      OFF_RUNP:   rdata_d = RDATA_W'(run_prio);
      OFF_HIPEND: rdata_d = RDATA_W'(hp_id);
      default:    rdata_d = '0;
    endcase
  end

  assign clr_id_d = ack_go ? best_id : clr_id_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_en_q <= 1'b0;
      pmask_q  <= 8'hF0;
      rdata_q  <= '0;
      clr_q    <= 1'b0;
      clr_id_q <= ID_NONE;
    end else begin
      cpu_en_q <= cpu_en_d;
      pmask_q  <= pmask_d;
      if (rd_stb) rdata_q <= rdata_d;
      clr_q    <= ack_go;
      clr_id_q <= clr_id_d;
    end
  end

  assign cpu_en      = cpu_en_q;
  assign pmask       = pmask_q;
  assign bus_rdata   = rdata_q;
  assign pend_clr    = clr_q;
  assign pend_clr_id = clr_id_q;
endmodule

// File: rtl/irq_cpu_if.sv
module irq_cpu_if
  import irq_cif_pkg::*;
#(
  parameter int NUM_IRQ = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      dist_en,
  input  logic [NUM_IRQ-1:0]        irq_enable,
  input  logic [NUM_IRQ-1:0]        irq_pend,
  input  logic [NUM_IRQ*8-1:0]      irq_prio,
  input  logic                      bus_sel,
  input  logic                      bus_wr,
  input  logic [7:0]                bus_addr,
  input  logic [9:0]                bus_wdata,
  output logic [31:0]               bus_rdata,
  output logic                      irq_out,
  output logic                      pend_clr,
  output logic [9:0]                pend_clr_id
);
  logic [ID_W-1:0]    best_id;
  logic [RPRIO_W-1:0] best_prio;
  logic [ID_W-1:0]    run_id;
  logic [RPRIO_W-1:0] run_prio;
  logic               cpu_en;
  logic [PRIO_W-1:0]  pmask;
  logic               ack_go, eoi_go;
  logic [ID_W-1:0]    ack_id, eoi_id;
  logic [PRIO_W-1:0]  ack_prio;

  irq_prio_search #(.NUM_IRQ(NUM_IRQ)) u_search (
    .clk(clk), .rst_n(rst_n),
    .cand_en(irq_enable), .cand_pend(irq_pend), .cand_prio(irq_prio),
    .best_id_q(best_id), .best_prio_q(best_prio)
  );

  irq_cif_regs u_regs (
    .clk(clk), .rst_n(rst_n), .dist_en(dist_en),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .best_id(best_id), .best_prio(best_prio), .run_prio(run_prio),
    .cpu_en(cpu_en), .pmask(pmask), .bus_rdata(bus_rdata), .irq_fire(irq_out),
    .ack_go(ack_go), .ack_id(ack_id), .ack_prio(ack_prio),
    .eoi_go(eoi_go), .eoi_id(eoi_id),
    .pend_clr(pend_clr), .pend_clr_id(pend_clr_id)
  );

  irq_nest_chain #(.NUM_IRQ(NUM_IRQ)) u_chain (
    .clk(clk), .rst_n(rst_n),
    .ack_go(ack_go), .ack_id(ack_id), .ack_prio(ack_prio),
    .eoi_go(eoi_go), .eoi_id(eoi_id), .cur_prio(irq_prio),
    .run_id(run_id), .run_prio(run_prio)
  );
endmodule

// File: rtl/irq_cpu_if_chk.sv
module irq_cpu_if_chk #(
  parameter int NUM_IRQ = 64
) (
  input logic       clk,
  input logic       rst_n,
  input logic       dist_en,
  input logic       cpu_en,
  input logic       bus_sel,
  input logic       bus_wr,
  input logic [7:0] bus_addr,
  input logic [9:0] bus_wdata,
  input logic       irq_out,
  input logic       pend_clr,
  input logic [9:0] pend_clr_id,
  input logic [8:0] run_prio,
  input logic [9:0] run_id
);
  AST_CLR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    pend_clr |=> !pend_clr); // R7
  AST_CLR_ID_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    pend_clr |-> (pend_clr_id < 10'(NUM_IRQ)) && (run_prio < 9'h100)); // R7
  AST_OUT_NEEDS_DIST: assert property (@(posedge clk) disable iff (!rst_n)
    !dist_en |-> !irq_out); // R5
  AST_OUT_NEEDS_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_en |-> !irq_out); // R5
  AST_BAD_EOI_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == 8'h10 && bus_wdata >= 10'(NUM_IRQ))
    |=> $stable(run_prio)); // R10
  AST_IDLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (run_prio == 9'h100) == (run_id == 10'd1023)); // R8
endmodule

bind irq_cpu_if irq_cpu_if_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .dist_en(dist_en), .cpu_en(cpu_en),
  .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .irq_out(irq_out), .pend_clr(pend_clr), .pend_clr_id(pend_clr_id),
  .run_prio(run_prio), .run_id(run_id)
);

// File: tb/sim_irq_cpu_if.sv
module sim_irq_cpu_if;
  localparam int N = 64;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          dist_en;
  logic [N-1:0]  irq_enable, irq_pend;
  logic [N*8-1:0] irq_prio;
  logic          bus_sel, bus_wr;
  logic [7:0]    bus_addr;
  logic [9:0]    bus_wdata;
  logic [31:0]   bus_rdata;
  logic          irq_out, pend_clr;
  logic [9:0]    pend_clr_id;

  int nchk = 0, nfail = 0;
  int chain[$];
  int m_cpu_en = 0, m_mask = 'hF0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  irq_cpu_if #(.NUM_IRQ(N)) u0 (
    .clk(clk), .rst_n(rst_n), .dist_en(dist_en), .irq_enable(irq_enable),
    .irq_pend(irq_pend), .irq_prio(irq_prio), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out), .pend_clr(pend_clr), .pend_clr_id(pend_clr_id)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int prio_of(input int id);
    return int'(irq_prio[id*8 +: 8]);
  endfunction

  function automatic void best(output int id, output int p);
    p = 256; id = 1023;
    for (int i = 0; i < N; i++)
      if (irq_enable[i] && irq_pend[i] && prio_of(i) < p) begin p = prio_of(i); id = i; end
  endfunction

  function automatic int runp_exp();
    return (chain.size() == 0) ? 256 : prio_of(chain[chain.size()-1]);
  endfunction

  function automatic int hp_exp();
    int id, p;
    best(id, p);
    return (dist_en && m_cpu_en != 0 && id != 1023 && p <= m_mask) ? id : 1023;
  endfunction

  function automatic int fire_exp();
    int id, p;
    best(id, p);
    return (hp_exp() != 1023 && p < runp_exp()) ? 1 : 0;
  endfunction

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic bus_read(input logic [7:0] a, output int d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = int'(bus_rdata);
  endtask

  task automatic bus_write(input logic [7:0] a, input int v);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = 10'(v);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic check_state(input string req);
    int d;
    chk(req, int'(irq_out), fire_exp());
    bus_read(8'h18, d); chk(req, d, hp_exp());
    bus_read(8'h14, d); chk(req, d, runp_exp());
  endtask

  task automatic do_ack(input string req);
    int d, exp_id;
    exp_id = (fire_exp() != 0) ? hp_exp() : 1023;
    bus_read(8'h0C, d);
    chk(req, d, exp_id);
    chk(req, int'(pend_clr), (exp_id != 1023) ? 1 : 0);
    if (exp_id != 1023) begin
      chk(req, int'(pend_clr_id), exp_id);
      chain.push_back(exp_id);
      irq_pend[exp_id] = 1'b0;
    end
    settle();
    chk(req, int'(pend_clr), 0);
  endtask

  task automatic do_eoi(input int id);
    bus_write(8'h10, id);
    if (id < N && chain.size() != 0)
      foreach (chain[k]) if (chain[k] == id) begin chain.delete(k); break; end
    settle();
  endtask

  task automatic set_mask(input int m);
    bus_write(8'h04, m); m_mask = m; settle();
  endtask

  initial begin
    #(8ns * 200000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int d;
    void'($urandom(32'h1A2B));
    rst_n = 1'b0; dist_en = 1'b0; irq_enable = '0; irq_pend = '0;
    irq_prio = {N{8'h80}}; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();

    // R1 reset state
    chk("R1 irq_out", int'(irq_out), 0);
    bus_read(8'h18, d); chk("R1 hipend", d, 1023);
    bus_read(8'h04, d); chk("R1 mask", d, 'hF0);
    bus_read(8'h14, d); chk("R1 runprio", d, 256);
    bus_read(8'h00, d); chk("R1 ctrl", d, 0);

    // R2 selection and ties
    dist_en = 1'b1; bus_write(8'h00, 1); m_cpu_en = 1; set_mask('hFF);
    irq_enable[5] = 1; irq_enable[9] = 1; irq_pend[5] = 1; irq_pend[9] = 1;
    irq_prio[5*8 +: 8] = 8'h40; irq_prio[9*8 +: 8] = 8'h20;
    settle();
    bus_read(8'h18, d); chk("R2 lowest value", d, 9);
    irq_prio[5*8 +: 8] = 8'h20; settle();
    bus_read(8'h18, d); chk("R2 tie low id", d, 5);
    chk("R4 fires", int'(irq_out), 1);
    irq_enable[5] = 0; settle();
    bus_read(8'h18, d); chk("R2 disabled skipped", d, 9);
    irq_enable[5] = 1; settle();

    // R3 mask
    set_mask('h10);
    bus_read(8'h18, d); chk("R3 masked hipend", d, 1023);
    chk("R3 masked irq", int'(irq_out), 0);
    set_mask('h20);
    bus_read(8'h18, d); chk("R3 equal to mask passes", d, 5);
    set_mask('hFF);

    // R5 enables
    dist_en = 1'b0; settle();
    chk("R5 dist off irq", int'(irq_out), 0);
    bus_read(8'h18, d); chk("R5 dist off hipend", d, 1023);
    dist_en = 1'b1; bus_write(8'h00, 0); m_cpu_en = 0; settle();
    chk("R5 cpu off irq", int'(irq_out), 0);
    bus_read(8'h18, d); chk("R5 cpu off hipend", d, 1023);
    bus_write(8'h00, 1); m_cpu_en = 1; settle();

    // R11 latency
    irq_pend = '0; settle();
    chk("R11 idle", int'(irq_out), 0);
    irq_enable[3] = 1; irq_prio[3*8 +: 8] = 8'h10; irq_pend[3] = 1;
    #1 chk("R11 before edge", int'(irq_out), 0);
    @(negedge clk); chk("R11 after one edge", int'(irq_out), 1);

    // R6/R7 acknowledge and nesting, R4 equal priority
    do_ack("R7 ack 3");
    check_state("R7 run prio 0x10");
    do_ack("R6 nothing qualifies");
    check_state("R6 no change");
    irq_enable[8] = 1; irq_prio[8*8 +: 8] = 8'h10; irq_pend[8] = 1; settle();
    chk("R4 equal no preempt", int'(irq_out), 0);
    irq_pend[8] = 0;
    irq_enable[7] = 1; irq_prio[7*8 +: 8] = 8'h08; irq_pend[7] = 1; settle();
    do_ack("R7 ack 7");
    irq_enable[2] = 1; irq_prio[2*8 +: 8] = 8'h04; irq_pend[2] = 1; settle();
    do_ack("R7 ack 2");
    bus_read(8'h14, d); chk("R7 nested prio", d, 4);

    // R9 splice, R8 restore, R10 ignore
    do_eoi(7);
    bus_read(8'h14, d); chk("R9 splice keeps run", d, 4);
    do_eoi(100);
    bus_read(8'h14, d); chk("R10 big id ignored", d, 4);
    do_eoi(2);
    bus_read(8'h14, d); chk("R9 restore skips spliced", d, 'h10);
    do_eoi(3);
    bus_read(8'h14, d); chk("R8 restore idle", d, 256);
    do_eoi(3);
    bus_read(8'h14, d); chk("R10 nothing running", d, 256);

    // random phase
    for (int it = 0; it < 400; it++) begin
      int op;
      if (chain.size() == 0 && ($urandom % 4) == 0) begin
        for (int i = 0; i < N; i++) irq_prio[i*8 +: 8] = 8'($urandom % 64);
        irq_enable = {$urandom, $urandom} | {$urandom, $urandom};
      end
      if (($urandom % 3) == 0) irq_pend[$urandom % N] = 1'b1;
      if (($urandom % 10) == 0) dist_en = ($urandom % 5) != 0;
      settle();
      op = $urandom % 8;
      case (op)
        0, 1, 2: do_ack("R7 random ack");
        3: if (chain.size() != 0) do_eoi(chain[chain.size()-1]);
        4: if (chain.size() != 0) do_eoi(chain[$urandom % chain.size()]);
        5: do_eoi($urandom % 80);
        6: set_mask((($urandom % 3) == 0) ? ($urandom % 64) : 'hFF);
        default: settle();
      endcase
      check_state("R2 random state");
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule